// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the serial front end of one device in a chain of devices that are configured one after another over a single data line. It watches the serial input for a fixed start pattern and then reads a length field that gives the number of data bits for the whole chain. Each bit is taken on the rising edge of the configuration clock. Every bit up to the end of the length field is repeated on the serial output, so each device further down the chain sees the same header.

After the header, the block keeps the first bits it receives and builds them into frames. Each complete frame goes to a local store through a one-cycle write strobe that carries an address. The serial output stays high while these frames are loaded, so downstream devices never see a start bit pair. When the local store is full, any further bits up to the length count are forwarded downstream. When the count is used up, the block raises done and ignores its input until it is reset. A length smaller than the local capacity raises an error flag and stops loading early.

Top module: `cfg_chain_rx`

## Requirements
- R1: While `rst` is high and after it, until the first header bit, `dout` is 1 and `done`, `err` and `wr_en` are 0.
- R2: `din` is sampled on the rising clock edge. `dout` changes only on the falling edge and carries the value chosen for the bit sampled at the rising edge just before.
- R3: Until the start pattern 8'hF2 (sent MSB first) has been matched, every input bit, idle ones included, is echoed on `dout`.
- R4: The 24 length bits that follow the pattern are read MSB first and echoed on `dout`.
- R5: Data bit j counts from 0, starting with the first bit after the length field. While j < CAP, where CAP = FRAME_LEN*NFRAMES, `dout` is 1.
- R6: Loaded bits fill frames MSB first, with the first bit landing in the MSB. After bit FRAME_LEN-1 of frame f, `wr_en` is 1 for one cycle, `wr_addr` is f and `wr_data` holds the frame.
- R7: Data bits with CAP <= j < length are forwarded to `dout` unchanged.
- R8: `done` rises in the cycle after the last counted bit is sampled and stays high. From then on `dout` is 1, no write happens, and a second start pattern is not echoed.
- R9: If the length is below CAP, `err` rises together with `done`, and a partly filled frame is never written.
- R10: A length of 0 raises `done` and `err` right after the last length bit, and no frame is written.
- R11: Only `rst` returns the block to pattern search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high restart |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out to the next device, updated on the falling edge |
| wr_en | output | 1 | One-cycle frame write strobe |
| wr_addr | output | $clog2(NFRAMES) | Index of the frame being written |
| wr_data | output | FRAME_LEN | Assembled frame, first bit in the MSB |
| done | output | 1 | Length count reached |
| err | output | 1 | Length was below local capacity |

## Verification
The bench sweeps every length from zero to a few bits past capacity, using more than one data pattern. This covers the off-by-one edges where the length is one below, equal to and one above the capacity, and a count that ends partway through a frame. A design that counts from the wrong bit would forward a local bit or keep a surplus bit, and that would show up as a `dout` mismatch at the capacity boundary. A design that writes a partial frame, or that misses done when the length is zero, would show a write strobe or a done value that the bench does not expect. Sending a second start pattern after done catches a design that goes back to pattern search on its own. A probe taken just after each rising edge catches an output that changes on the wrong edge.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LEN,
        ST_BODY,
        ST_DONE
    } rx_state_e;

    typedef enum logic {
        SEL_MARK,
        SEL_PASS
    } out_sel_e;

    function automatic logic pick_out(input out_sel_e sel, input logic bit_in);
        return (sel == SEL_PASS) ? bit_in : 1'b1;
    endfunction

endpackage

// File: rtl/cc_pre_detect.sv
module cc_pre_detect #(
    parameter int          PAT_W = 8,
    parameter logic [PAT_W-1:0] PAT = 8'hF2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    logic [PAT_W-2:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '1;
        else     hist_q <= {hist_q[PAT_W-3:0], din};
    end

    assign hit = ({hist_q, din} == PAT);
endmodule

// File: rtl/cc_frame_asm.sv
module cc_frame_asm #(
    parameter int FRAME_LEN = 16,
    parameter int NFRAMES   = 4,
    localparam int BW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
    localparam int AW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 din,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [FRAME_LEN-1:0] wr_data
);
    logic [FRAME_LEN-2:0] part_q;
    logic [BW-1:0]        pos_q;
    logic [AW-1:0]        fidx_q;
    logic                 last;

    assign last = (pos_q == BW'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            pos_q   <= '0;
            fidx_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (en) begin
                part_q <= {part_q[FRAME_LEN-3:0], din};
                if (last) begin
                    pos_q   <= '0;
                    fidx_q  <= fidx_q + 1'b1;
                    wr_en   <= 1'b1;
                    wr_addr <= fidx_q;
                    wr_data <= {part_q, din};
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cc_out_stage.sv
module cc_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic bit_d,
    output logic bit_q,
    output logic dout
);
    always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b1;
        else     bit_q <= bit_d;
    end

    always_ff @(negedge clk) begin
        if (rst) dout <= 1'b1;
        else     dout <= bit_q;
    end
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
    import cfgchain_pkg::*;
#(
    parameter int               PAT_W     = 8,
    parameter logic [PAT_W-1:0] PAT       = 8'hF2,
    parameter int               LEN_W     = 24,
    parameter int               FRAME_LEN = 16,
    parameter int               NFRAMES   = 4,
    localparam int CAP = FRAME_LEN * NFRAMES,
    localparam int AW  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1,
    localparam int IW  = $clog2(LEN_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    output logic                 dout,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [FRAME_LEN-1:0] wr_data,
    output logic                 done,
    output logic                 err
);
    localparam logic [LEN_W-1:0] CAP_L = LEN_W'(CAP);

    rx_state_e        state_q, state_n;
    logic [IW-1:0]    idx_q, idx_n;
    logic [LEN_W-1:0] len_q, len_n, len_shift;
    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic             done_n, err_n;
    logic             hit, load_en, out_d, out_q;
    out_sel_e         sel;

    cc_pre_detect #(.PAT_W(PAT_W), .PAT(PAT)) u_det (
        .clk(clk), .rst(rst), .din(din), .hit(hit)
    );

    cc_frame_asm #(.FRAME_LEN(FRAME_LEN), .NFRAMES(NFRAMES)) u_asm (
        .clk(clk), .rst(rst), .en(load_en), .din(din),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign len_shift = {len_q[LEN_W-2:0], din};

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        len_n   = len_q;
        cnt_n   = cnt_q;
        done_n  = done;
        err_n   = err;
        load_en = 1'b0;
        sel     = SEL_MARK;
        case (state_q)
            ST_HUNT: begin
                sel = SEL_PASS;
                if (hit) begin
                    state_n = ST_LEN;
                    idx_n   = '0;
                end
            end
            ST_LEN: begin
                sel   = SEL_PASS;
                len_n = len_shift;
                idx_n = idx_q + 1'b1;
                if (idx_q == IW'(LEN_W - 1)) begin
                    cnt_n = '0;
                    if (len_shift == '0) begin
                        state_n = ST_DONE;
                        done_n  = 1'b1;
                        err_n   = 1'b1;
                    end else begin
                        state_n = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                cnt_n = cnt_q + 1'b1;
                if (cnt_q < CAP_L) load_en = 1'b1;
                else               sel     = SEL_PASS;
                if (cnt_n == len_q) begin
                    state_n = ST_DONE;
                    done_n  = 1'b1;
                    err_n   = (len_q < CAP_L);
                end
            end
            default: sel = SEL_MARK;
        endcase
        out_d = pick_out(sel, din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            len_q   <= len_n;
            cnt_q   <= cnt_n;
            done    <= done_n;
            err     <= err_n;
        end
    end

    cc_out_stage u_out (
        .clk(clk), .rst(rst), .bit_d(out_d), .bit_q(out_q), .dout(dout)
    );
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk (
    input logic clk,
    input logic rst,
    input logic dout,
    input logic bit_q,
    input logic wr_en,
    input logic done,
    input logic err
);
    // R2: the falling-edge flop shows the value picked at the rising edge
    a_r2_fall_edge_out: assert property (@(posedge clk) disable iff (rst)
        dout == bit_q);

    // R6: a write strobe lasts one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R8: done holds until reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8: no write once done has been seen
    a_r8_no_wr_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !wr_en);

    // R9: the error flag comes only with done
    a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
endmodule

bind cfg_chain_rx cfg_chain_rx_chk u_chk (
    .clk(clk), .rst(rst), .dout(dout), .bit_q(out_q),
    .wr_en(wr_en), .done(done), .err(err)
);

// File: tb/test_cfg_chain_rx.sv
`timescale 1ns/1ps
module test_cfg_chain_rx;
    localparam int FL  = 4;
    localparam int NF  = 3;
    localparam int LW  = 24;
    localparam int CAP = FL * NF;
    localparam logic [7:0] PAT = 8'hF2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b1;
    logic dout, wr_en, done, err;
    logic [1:0]    wr_addr;
    logic [FL-1:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic last_dout = 1'b1;

    logic          exp_wr;
    logic [FL-1:0] exp_data;
    int            exp_addr;
    logic          exp_done, exp_err;

    always #2 clk = ~clk;

    cfg_chain_rx #(.LEN_W(LW), .FRAME_LEN(FL), .NFRAMES(NF)) i_cfg_chain_rx (
        .clk(clk), .rst(rst), .din(din), .dout(dout), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive one bit, wait for the edge, probe before and after the falling edge
    task automatic send_bit(input logic b, input logic exp_d, input string req);
        din = b;
        @(posedge clk);
        #1;
        check("R2 dout held across rising edge", int'(dout), int'(last_dout));
        #2;
        check(req, int'(dout), int'(exp_d));
        last_dout = dout;
        check("R6 wr_en", int'(wr_en), int'(exp_wr));
        if (exp_wr) begin
            check("R6 wr_data", int'(wr_data), int'(exp_data));
            check("R6 wr_addr", int'(wr_addr), exp_addr);
        end
        check("R8 done", int'(done), int'(exp_done));
        check("R9 err", int'(err), int'(exp_err));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        check("R1 reset dout", int'(dout), 1);
        check("R1 reset done", int'(done), 0);
        check("R1 reset err", int'(err), 0);
        check("R1 reset wr_en", int'(wr_en), 0);
        last_dout = dout;
        rst = 1'b0;
    endtask

    task automatic session(input int len, input int seed);
        logic bits [0:63];
        logic [LW-1:0] lv;
        int loaded;
        exp_wr = 0; exp_data = '0; exp_addr = 0; exp_done = 0; exp_err = 0;
        do_reset();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1, "R3 idle echo");
        for (int i = 7; i >= 0; i--) send_bit(PAT[i], PAT[i], "R3 pattern echo");
        lv = LW'(len);
        for (int i = LW - 1; i >= 0; i--) begin
            if (i == 0 && len == 0) begin
                exp_done = 1; exp_err = 1;   // R10
            end
            send_bit(lv[i], lv[i], "R4 length echo");
        end
        loaded = (len < CAP) ? len : CAP;
        for (int j = 0; j < len; j++) begin
            logic b;
            b = (((j * 7 + seed * 3) % 5) < 2);
            bits[j] = b;
            exp_wr = 0;
            if (j < loaded && (j % FL) == FL - 1) begin
                exp_wr = 1;
                exp_addr = j / FL;
                for (int k = 0; k < FL; k++) exp_data[FL-1-k] = bits[j-FL+1+k];
            end
            if (j == len - 1) begin
                exp_done = 1;
                exp_err = (len < CAP);   // R9
            end
            if (j < CAP) send_bit(b, 1'b1, "R5 hold high while loading");
            else         send_bit(b, b, "R7 surplus forwarded");
        end
        exp_wr = 0;
        // R8 / R11: input ignored after done, a new pattern is not echoed
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b1, "R8 ignore after done");
        for (int i = 7; i >= 0; i--) send_bit(PAT[i], 1'b1, "R11 no restart without reset");
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1, "R11 no restart without reset");
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int seed = 0; seed < 2; seed++)
            for (int len = 0; len <= CAP + 5; len++)
                session(len, seed);
        session(CAP + 20, 3);
        do_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule